// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects the frame events of a multi-channel display controller, keeps them in two status registers and drives one interrupt line. Channel 0 is the base plane and reports into a global status register, next to controller-wide conditions such as quick disable, last-frame-done, bus error and read status. Channels 1 and up each own one bit per event kind in a second, per-channel status register. Every source has a mask bit. The channel 0 masks sit in the main control register and the per-channel masks sit in a second control register whose bit layout matches the per-channel status register.

Event generation lies outside the block. Each event arrives as a one-cycle pulse together with the frame ID and the command word of its channel. The first unmasked event seen while the line is low loads its frame ID into the interrupt-ID register. An unmasked event that arrives while the line is already high sets a subsequent-interrupt flag and leaves the ID alone. Software acknowledges events by writing ones to the status registers, and reaches the two control registers through the same write port.

Top module: `disp_irq_status`

## Requirements
- R1: A channel 0 start-of-frame pulse sets status0 bit 1 and an end-of-frame pulse sets bit 8, each only when the channel's command word has bit 22 (start) or bit 21 (end) set. A branch-status pulse sets bit 9 whatever the command word holds.
- R2: For channel c from 1 to NUM_CH-1, start of frame sets status1 bit c-1, end of frame sets bit c+7 and branch status sets bit c+15. Start and end are gated by command bits 22 and 21 as in R1.
- R3: irq_o is high exactly when an unmasked source is set. The status0 sources and their control0 masks are: bit 0 by bit 3, bit 1 by bit 4, bit 4 by bit 5, bit 6 by bit 21, bit 7 by bit 11, bit 8 by bit 6, bit 9 by bit 20, bit 11 by bit 23, bit 12 by bit 24. Status0 bit 5 is masked by control5 bit 24. Every status1 bit is masked by the control5 bit at the same position. Status0 bits 2, 3 and 10 never drive the line.
- R4: A masked event still sets its status bit, but it neither loads the ID nor sets bit 10. If unmasked events arrive while irq_o is low, the frame ID of the lowest-numbered such channel is loaded into irq_id_o. If they arrive while irq_o is high, status0 bit 10 is set and irq_id_o keeps its value.
- R5: A bus-error pulse on any channel sets status0 bit 2 and writes the lowest erroring channel number into status0 bits 30:28. A bus error counts as an unmasked event for R4.
- R6: Writing status0 (reg_sel 2) clears the bits among 11:0 that are written as one. A one in bit 2 also clears bits 30:28. A status bit set by an event in the same cycle stays set.
- R7: Writing status1 (reg_sel 3) clears only written-one bits inside the mask 0x003E3F3F. Bit 16 and bits 22 and above are not cleared.
- R8: Writing control0 (reg_sel 0) stores the value ANDed with 0x07FFFFFF. When such a write takes bit 0 from 1 to 0, status0 bit 7 is set.
- R9: A frame-done pulse while control0 bits 0 and 10 are both set clears control0 bit 0 and sets status0 bit 1's neighbour bit 0 (last frame done). Without bit 10 the pulse has no effect.
- R10: Writing control5 (reg_sel 1) stores the value ANDed with 0x3F3F3F3F.
- R11: A read-status pulse sets status0 bit 11. It sets bit 10 only when irq_o is already high and control0 bit 23 is clear, and it never changes irq_id_o.
- R12: After reset every status, control and ID output is zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 control0, 1 control5, 2 status0, 3 status1 |
| reg_wdata | input | 32 | Write data |
| ev_sof | input | NUM_CH | Start-of-frame pulse per channel |
| ev_eof | input | NUM_CH | End-of-frame pulse per channel |
| ev_bs | input | NUM_CH | Branch-status pulse per channel |
| ev_ber | input | NUM_CH | Bus-error pulse per channel |
| ev_rdst | input | 1 | Read-status pulse |
| ev_frame_done | input | 1 | Base-plane frame completed |
| ch_id | input | NUM_CH*ID_W | Frame ID of each channel, channel 0 in the low bits |
| ch_cmd | input | NUM_CH*32 | Command word of each channel |
| irq_o | output | 1 | Interrupt line |
| status0_o | output | 32 | Global status register |
| status1_o | output | 32 | Per-channel status register |
| ctrl0_o | output | 32 | Control register 0 |
| ctrl5_o | output | 32 | Per-channel mask register |
| irq_id_o | output | ID_W | Latched interrupt frame ID |

## Verification
The hardest case is the split between ID loading and the subsequent flag. It depends on the line level that was left by earlier events, and on several channels reporting in the same clock. The bench first raises the line with one event, or with a group of simultaneous channels to check that the lowest index wins. It then sends further masked and unmasked events. A status clear and a new event are also driven in the same cycle so that the set-wins rule is exercised. The sticky status1 bits outside the clear mask are filled by pulsing every channel at once and then writing all ones.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      SEL_CTRL0 = 2'd0,
      SEL_CTRL5 = 2'd1,
      SEL_STAT0 = 2'd2,
      SEL_STAT1 = 2'd3
   } reg_sel_e;

   // global status bit positions
   localparam int S0_LDD   = 0;
   localparam int S0_SOF0  = 1;
   localparam int S0_BER   = 2;
   localparam int S0_IU0   = 4;
   localparam int S0_IU1   = 5;
   localparam int S0_OU    = 6;
   localparam int S0_QD    = 7;
   localparam int S0_EOF0  = 8;
   localparam int S0_BS0   = 9;
   localparam int S0_SINT  = 10;
   localparam int S0_RDST  = 11;
   localparam int S0_CMD   = 12;
   localparam int S0_BCH_LO = 28;
   localparam logic [REG_W-1:0] S0_CLR = 32'h0000_0FFF;

   // control0 bit positions
   localparam int C0_ENB   = 0;
   localparam int C0_LDM   = 3;
   localparam int C0_SOFM  = 4;
   localparam int C0_IUM   = 5;
   localparam int C0_EOFM  = 6;
   localparam int C0_DIS   = 10;
   localparam int C0_QDM   = 11;
   localparam int C0_BSM   = 20;
   localparam int C0_OUM   = 21;
   localparam int C0_RDSTM = 23;
   localparam int C0_CMDIM = 24;
   localparam logic [REG_W-1:0] C0_KEEP = 32'h07FF_FFFF;

   // command word interrupt enables
   localparam int CMD_EOF_EN = 21;
   localparam int CMD_SOF_EN = 22;

   // per-channel register group offsets (channel c at offset + c - 1)
   localparam int G_SOF = 0;
   localparam int G_EOF = 8;
   localparam int G_BS  = 16;
   localparam int G_IU  = 24;

   function automatic logic [REG_W-1:0] ctrl5_keep(int n_ch);
      logic [REG_W-1:0] m;
      m = '0;
      for (int g = 0; g < 4; g++)
         for (int k = 0; k < n_ch - 1; k++)
            m[g*8 + k] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/dirq_chan_decode.sv
module dirq_chan_decode
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7
) (
   input  logic [NUM_CH-1:0]       ev_sof,
   input  logic [NUM_CH-1:0]       ev_eof,
   input  logic [NUM_CH-1:0]       ev_bs,
   input  logic [NUM_CH-1:0]       ev_ber,
   input  logic [NUM_CH*REG_W-1:0] ch_cmd,
   input  logic [REG_W-1:0]        ctrl0,
   input  logic [REG_W-1:0]        ctrl5,
   output logic [REG_W-1:0]        set0,
   output logic [REG_W-1:0]        set1,
   output logic [NUM_CH-1:0]       unm,
   output logic                    ber_any,
   output logic [2:0]              ber_ch
);
   logic [NUM_CH-1:0] sof_hit, eof_hit, m_sof, m_eof, m_bs;
   logic unused_inputs;

   assign unused_inputs = ^{ch_cmd, ctrl0, ctrl5};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign sof_hit[c] = ev_sof[c] & ch_cmd[c*REG_W + CMD_SOF_EN];
      assign eof_hit[c] = ev_eof[c] & ch_cmd[c*REG_W + CMD_EOF_EN];
      if (c == 0) begin : g_glb
         assign m_sof[c] = ctrl0[C0_SOFM];
         assign m_eof[c] = ctrl0[C0_EOFM];
         assign m_bs[c]  = ctrl0[C0_BSM];
      end else begin : g_loc
         assign m_sof[c] = ctrl5[G_SOF + c - 1];
         assign m_eof[c] = ctrl5[G_EOF + c - 1];
         assign m_bs[c]  = ctrl5[G_BS + c - 1];
      end
      assign unm[c] = (sof_hit[c] & ~m_sof[c]) | (eof_hit[c] & ~m_eof[c])
                    | (ev_bs[c] & ~m_bs[c]) | ev_ber[c];
   end

   always_comb begin
      set0 = '0;
      set0[S0_SOF0] = sof_hit[0];
      set0[S0_EOF0] = eof_hit[0];
      set0[S0_BS0]  = ev_bs[0];
      set0[S0_BER]  = |ev_ber;
      set1 = '0;
      for (int c = 1; c < NUM_CH; c++) begin
         set1[G_SOF + c - 1] = sof_hit[c];
         set1[G_EOF + c - 1] = eof_hit[c];
         set1[G_BS + c - 1]  = ev_bs[c];
      end
   end

   always_comb begin
      ber_any = |ev_ber;
      ber_ch  = '0;
      for (int c = NUM_CH - 1; c >= 0; c--)
         if (ev_ber[c]) ber_ch = 3'(c);
   end
endmodule

// File: rtl/dirq_id_pick.sv
module dirq_id_pick #(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32
) (
   input  logic [NUM_CH-1:0]      req,
   input  logic [NUM_CH*ID_W-1:0] ids,
   output logic                   hit,
   output logic [ID_W-1:0]        id
);
   always_comb begin
      hit = 1'b0;
      id  = '0;
      for (int c = NUM_CH - 1; c >= 0; c--)
         if (req[c]) begin
            hit = 1'b1;
            id  = ids[c*ID_W +: ID_W];
         end
   end
endmodule

// File: rtl/dirq_ctrl_regs.sv
module dirq_ctrl_regs
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_c0,
   input  logic             wr_c5,
   input  logic [REG_W-1:0] wdata,
   input  logic             frame_done,
   output logic [REG_W-1:0] ctrl0,
   output logic [REG_W-1:0] ctrl5,
   output logic             qd_set,
   output logic             ldd_set
);
   localparam logic [REG_W-1:0] C5_KEEP = ctrl5_keep(NUM_CH);

   assign qd_set  = wr_c0 & ctrl0[C0_ENB] & ~wdata[C0_ENB];
   assign ldd_set = frame_done & ctrl0[C0_ENB] & ctrl0[C0_DIS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0 <= '0;
         ctrl5 <= '0;
      end else begin
         if (wr_c0)        ctrl0 <= wdata & C0_KEEP;
         else if (ldd_set) ctrl0[C0_ENB] <= 1'b0;
         if (wr_c5)        ctrl5 <= wdata & C5_KEEP;
      end
   end
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32,
   parameter logic [31:0] ST1_CLR = 32'h003E_3F3F
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [1:0]             reg_sel,
   input  logic [31:0]            reg_wdata,
   input  logic [NUM_CH-1:0]      ev_sof,
   input  logic [NUM_CH-1:0]      ev_eof,
   input  logic [NUM_CH-1:0]      ev_bs,
   input  logic [NUM_CH-1:0]      ev_ber,
   input  logic                   ev_rdst,
   input  logic                   ev_frame_done,
   input  logic [NUM_CH*ID_W-1:0] ch_id,
   input  logic [NUM_CH*32-1:0]   ch_cmd,
   output logic                   irq_o,
   output logic [31:0]            status0_o,
   output logic [31:0]            status1_o,
   output logic [31:0]            ctrl0_o,
   output logic [31:0]            ctrl5_o,
   output logic [ID_W-1:0]        irq_id_o
);
   if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
      $error("disp_irq_status: NUM_CH must lie in 2..8");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("disp_irq_status: ID_W must be positive");
   end

   logic [REG_W-1:0] st0_q, st1_q, st0_nxt, st1_nxt, c0, c5;
   logic [REG_W-1:0] dec_set0, dec_set1, set0_all, clr0, clr1;
   logic [ID_W-1:0]  id_q, pick_id;
   logic [NUM_CH-1:0] unm;
   logic wr_c0, wr_c5, wr_s0, wr_s1;
   logic qd_set, ldd_set, ber_any, pick_hit, rdst_unm, sint_set;
   logic [2:0] ber_ch;

   assign wr_c0 = reg_we & (reg_sel == SEL_CTRL0);
   assign wr_c5 = reg_we & (reg_sel == SEL_CTRL5);
   assign wr_s0 = reg_we & (reg_sel == SEL_STAT0);
   assign wr_s1 = reg_we & (reg_sel == SEL_STAT1);

   dirq_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_c0      (wr_c0),
      .wr_c5      (wr_c5),
      .wdata      (reg_wdata),
      .frame_done (ev_frame_done),
      .ctrl0      (c0),
      .ctrl5      (c5),
      .qd_set     (qd_set),
      .ldd_set    (ldd_set)
   );

   dirq_chan_decode #(.NUM_CH(NUM_CH)) u_dec (
      .ev_sof  (ev_sof),
      .ev_eof  (ev_eof),
      .ev_bs   (ev_bs),
      .ev_ber  (ev_ber),
      .ch_cmd  (ch_cmd),
      .ctrl0   (c0),
      .ctrl5   (c5),
      .set0    (dec_set0),
      .set1    (dec_set1),
      .unm     (unm),
      .ber_any (ber_any),
      .ber_ch  (ber_ch)
   );

   dirq_id_pick #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_pick (
      .req (unm),
      .ids (ch_id),
      .hit (pick_hit),
      .id  (pick_id)
   );

   // interrupt line from registered status and masks
   assign irq_o = (st0_q[S0_LDD]  & ~c0[C0_LDM])
                | (st0_q[S0_SOF0] & ~c0[C0_SOFM])
                | (st0_q[S0_IU0]  & ~c0[C0_IUM])
                | (st0_q[S0_IU1]  & ~c5[G_IU])
                | (st0_q[S0_OU]   & ~c0[C0_OUM])
                | (st0_q[S0_QD]   & ~c0[C0_QDM])
                | (st0_q[S0_EOF0] & ~c0[C0_EOFM])
                | (st0_q[S0_BS0]  & ~c0[C0_BSM])
                | (st0_q[S0_RDST] & ~c0[C0_RDSTM])
                | (st0_q[S0_CMD]  & ~c0[C0_CMDIM])
                | (|(st1_q & ~c5));

   assign rdst_unm = ev_rdst & ~c0[C0_RDSTM];
   assign sint_set = irq_o & (pick_hit | rdst_unm);

   always_comb begin
      set0_all = dec_set0;
      set0_all[S0_QD]   = qd_set;
      set0_all[S0_LDD]  = ldd_set;
      set0_all[S0_RDST] = ev_rdst;
      set0_all[S0_SINT] = sint_set;
      clr0 = wr_s0 ? (reg_wdata & S0_CLR) : '0;
      clr1 = wr_s1 ? (reg_wdata & ST1_CLR) : '0;
      st0_nxt = (st0_q & ~clr0) | set0_all;
      if (ber_any)
         st0_nxt[S0_BCH_LO +: 3] = ber_ch;
      else if (wr_s0 && reg_wdata[S0_BER])
         st0_nxt[S0_BCH_LO +: 3] = 3'd0;
      st1_nxt = (st1_q & ~clr1) | dec_set1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st0_q <= '0;
         st1_q <= '0;
         id_q  <= '0;
      end else begin
         st0_q <= st0_nxt;
         st1_q <= st1_nxt;
         if (pick_hit && !irq_o) id_q <= pick_id;
      end
   end

   assign status0_o = st0_q;
   assign status1_o = st1_q;
   assign ctrl0_o   = c0;
   assign ctrl5_o   = c5;
   assign irq_id_o  = id_q;
endmodule

// File: rtl/dirq_status_chk.sv
module dirq_status_chk #(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32,
   parameter logic [31:0] ST1_CLR = 32'h003E_3F3F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [1:0]        reg_sel,
   input logic [31:0]       reg_wdata,
   input logic [NUM_CH-1:0] ev_sof,
   input logic [NUM_CH-1:0] ev_eof,
   input logic [NUM_CH-1:0] ev_bs,
   input logic              ev_rdst,
   input logic              ev_frame_done,
   input logic              irq_o,
   input logic [31:0]       status0_o,
   input logic [31:0]       status1_o,
   input logic [31:0]       ctrl0_o,
   input logic [31:0]       ctrl5_o,
   input logic [ID_W-1:0]   irq_id_o
);
   localparam logic [31:0] KEEP5 = dirq_pkg::ctrl5_keep(NUM_CH);

   // R3
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status0_o == 32'd0 && status1_o == 32'd0) |-> !irq_o);

   // R4
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> $stable(irq_id_o));

   // R7
   st1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd3 && ev_sof == '0 && ev_eof == '0 && ev_bs == '0)
      |=> ((status1_o & $past(reg_wdata) & ST1_CLR) == 32'd0));

   // R8
   quick_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd0 && ctrl0_o[0] && !reg_wdata[0]) |=> status0_o[7]);

   // R9
   last_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_frame_done && ctrl0_o[0] && ctrl0_o[10] && !(reg_we && reg_sel == 2'd0))
      |=> (!ctrl0_o[0] && status0_o[0]));

   // R10
   ctrl5_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd1) |=> (ctrl5_o == ($past(reg_wdata) & KEEP5)));

   // R11
   rdst_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ev_rdst && !ctrl0_o[23]) |=> status0_o[10]);
endmodule

bind disp_irq_status dirq_status_chk #(
   .NUM_CH(NUM_CH), .ID_W(ID_W), .ST1_CLR(ST1_CLR)
) u_dirq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_sel       (reg_sel),
   .reg_wdata     (reg_wdata),
   .ev_sof        (ev_sof),
   .ev_eof        (ev_eof),
   .ev_bs         (ev_bs),
   .ev_rdst       (ev_rdst),
   .ev_frame_done (ev_frame_done),
   .irq_o         (irq_o),
   .status0_o     (status0_o),
   .status1_o     (status1_o),
   .ctrl0_o       (ctrl0_o),
   .ctrl5_o       (ctrl5_o),
   .irq_id_o      (irq_id_o)
);

// File: tb/test_disp_irq_status.sv
`timescale 1ns/1ps
module test_disp_irq_status;
   localparam int NCH = 7;
   localparam int IDW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [NCH-1:0] ev_sof = '0, ev_eof = '0, ev_bs = '0, ev_ber = '0;
   logic ev_rdst = 1'b0, ev_frame_done = 1'b0;
   logic [NCH*IDW-1:0] ch_id;
   logic [NCH*32-1:0] ch_cmd;
   logic irq_o;
   logic [31:0] status0_o, status1_o, ctrl0_o, ctrl5_o;
   logic [IDW-1:0] irq_id_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   disp_irq_status #(.NUM_CH(NCH), .ID_W(IDW)) i_disp_irq_status (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bs(ev_bs),
      .ev_ber(ev_ber), .ev_rdst(ev_rdst), .ev_frame_done(ev_frame_done),
      .ch_id(ch_id), .ch_cmd(ch_cmd), .irq_o(irq_o), .status0_o(status0_o),
      .status1_o(status1_o), .ctrl0_o(ctrl0_o), .ctrl5_o(ctrl5_o),
      .irq_id_o(irq_id_o)
   );

   function automatic logic [31:0] fid(int c);
      return 32'hC0DE_0000 + 32'(c) * 32'h111;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic all_cmd_on();
      for (int c = 0; c < NCH; c++) ch_cmd[c*32 +: 32] = 32'h0060_0000;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      reg_we = 1'b0;
      ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_ber = '0;
      ev_rdst = 1'b0; ev_frame_done = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic pulse(logic [NCH-1:0] s, logic [NCH-1:0] e, logic [NCH-1:0] b,
                        logic [NCH-1:0] be, logic rd, logic fd);
      @(negedge clk);
      ev_sof = s; ev_eof = e; ev_bs = b; ev_ber = be; ev_rdst = rd; ev_frame_done = fd;
      @(posedge clk); #1;
      ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_ber = '0; ev_rdst = 1'b0; ev_frame_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) ch_id[c*IDW +: IDW] = fid(c);
      all_cmd_on();
      do_reset();
      // R12 reset state
      chk("R12 status0", status0_o, 0);
      chk("R12 status1", status1_o, 0);
      chk("R12 ctrl0", ctrl0_o, 0);
      chk("R12 ctrl5", ctrl5_o, 0);
      chk("R12 id", irq_id_o, 0);
      chk("R12 irq", 32'(irq_o), 0);

      // R1 / R2 sweep: every channel, event kind and command gate
      for (int c = 0; c < NCH; c++)
         for (int t = 0; t < 3; t++)
            for (int en = 0; en < 2; en++) begin
               logic [NCH-1:0] v;
               logic gate;
               logic [31:0] e0, e1;
               string tag;
               do_reset();
               ch_cmd[c*32 +: 32] = (en != 0) ? 32'h0060_0000 : 32'h0;
               v = NCH'(1) << c;
               pulse(t == 0 ? v : '0, t == 1 ? v : '0, t == 2 ? v : '0, '0, 1'b0, 1'b0);
               gate = (t == 2) || (en != 0);
               e0 = '0; e1 = '0;
               if (gate) begin
                  if (c == 0) e0 = 32'd1 << (t == 0 ? 1 : (t == 1 ? 8 : 9));
                  else        e1 = 32'd1 << (t*8 + c - 1);
               end
               tag = (c == 0) ? "R1" : "R2";
               chk(tag, status0_o, e0);
               chk(tag, status1_o, e1);
               chk("R3 line", 32'(irq_o), 32'(gate));
               chk("R4 id", irq_id_o, gate ? fid(c) : 32'd0);
               all_cmd_on();
            end

      // R3 / R4 mask sweep
      for (int c = 0; c < NCH; c++)
         for (int t = 0; t < 3; t++) begin
            logic [NCH-1:0] v;
            do_reset();
            if (c == 0) wr(2'd0, 32'd1 << (t == 0 ? 4 : (t == 1 ? 6 : 20)));
            else        wr(2'd1, 32'd1 << (t*8 + c - 1));
            v = NCH'(1) << c;
            pulse(t == 0 ? v : '0, t == 1 ? v : '0, t == 2 ? v : '0, '0, 1'b0, 1'b0);
            if (c == 0) chk("R3 masked sets", status0_o, 32'd1 << (t == 0 ? 1 : (t == 1 ? 8 : 9)));
            else        chk("R3 masked sets", status1_o, 32'd1 << (t*8 + c - 1));
            chk("R3 masked line", 32'(irq_o), 0);
            chk("R4 masked id", irq_id_o, 0);
         end

      // R4 priority and subsequent flag
      do_reset();
      pulse(7'b0101100, '0, '0, '0, 1'b0, 1'b0);
      chk("R4 lowest id", irq_id_o, fid(2));
      chk("R2 multi", status1_o, 32'h16);
      pulse('0, 7'b0010000, '0, '0, 1'b0, 1'b0);
      chk("R4 sub flag", status0_o, 32'h400);
      chk("R4 id kept", irq_id_o, fid(2));
      chk("R2 eof4", status1_o, 32'h816);
      wr(2'd2, 32'h400);
      chk("R6 clear sint", status0_o, 0);
      wr(2'd1, 32'h1000);
      pulse('0, 7'b0100000, '0, '0, 1'b0, 1'b0);
      chk("R4 masked no sub", status0_o, 0);
      chk("R4 masked status", status1_o, 32'h1816);

      // R5 bus error
      do_reset();
      pulse('0, '0, '0, 7'b0101000, 1'b0, 1'b0);
      chk("R5 status", status0_o, 32'h3000_0004);
      chk("R5 id", irq_id_o, fid(3));
      chk("R5 no line", 32'(irq_o), 0);
      wr(2'd2, 32'h4);
      chk("R6 ber clear", status0_o, 0);
      pulse(7'b0000001, '0, '0, '0, 1'b0, 1'b0);
      pulse('0, '0, '0, 7'b1000000, 1'b0, 1'b0);
      chk("R5 sub", status0_o, 32'h6000_0406);
      chk("R5 id kept", irq_id_o, fid(0));

      // R6 set wins over clear in the same cycle
      do_reset();
      pulse(7'b0000001, '0, '0, '0, 1'b0, 1'b0);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h2; ev_sof = 7'b0000001;
      @(posedge clk); #1;
      reg_we = 1'b0; ev_sof = '0;
      chk("R6 set wins", status0_o, 32'h402);
      wr(2'd2, 32'hFFFF_FFFF);
      chk("R6 clear all", status0_o, 0);

      // R7 status1 clear mask
      do_reset();
      pulse(7'b1111110, 7'b1111110, 7'b1111110, '0, 1'b0, 1'b0);
      chk("R2 all", status1_o, 32'h003F_3F3F);
      chk("R4 all id", irq_id_o, fid(1));
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R7 sticky", status1_o, 32'h0001_0000);
      chk("R7 line", 32'(irq_o), 1);
      wr(2'd1, 32'h0001_0000);
      chk("R3 status1 mask", 32'(irq_o), 0);

      // R8 / R10 control writes
      do_reset();
      wr(2'd0, 32'hFFFF_FFFF);
      chk("R8 keep", ctrl0_o, 32'h07FF_FFFF);
      chk("R8 no qd", status0_o, 0);
      wr(2'd0, 32'h0);
      chk("R8 qd", status0_o, 32'h80);
      chk("R3 qd line", 32'(irq_o), 1);
      do_reset();
      wr(2'd0, 32'h801);
      wr(2'd0, 32'h800);
      chk("R8 qd masked", status0_o, 32'h80);
      chk("R3 qd masked line", 32'(irq_o), 0);
      wr(2'd1, 32'hFFFF_FFFF);
      chk("R10 keep", ctrl5_o, 32'h3F3F_3F3F);

      // R9 last frame done
      do_reset();
      wr(2'd0, 32'h401);
      pulse('0, '0, '0, '0, 1'b0, 1'b1);
      chk("R9 enb cleared", ctrl0_o, 32'h400);
      chk("R9 ldd", status0_o, 32'h1);
      chk("R9 line", 32'(irq_o), 1);
      do_reset();
      wr(2'd0, 32'h1);
      pulse('0, '0, '0, '0, 1'b0, 1'b1);
      chk("R9 no dis ctrl", ctrl0_o, 32'h1);
      chk("R9 no dis status", status0_o, 0);

      // R11 read status
      do_reset();
      pulse('0, '0, '0, '0, 1'b1, 1'b0);
      chk("R11 set", status0_o, 32'h800);
      chk("R11 line", 32'(irq_o), 1);
      chk("R11 id", irq_id_o, 0);
      pulse('0, '0, '0, '0, 1'b1, 1'b0);
      chk("R11 sub", status0_o, 32'hC00);
      chk("R11 id kept", irq_id_o, 0);
      do_reset();
      wr(2'd0, 32'h0080_0000);
      pulse(7'b0000001, '0, '0, '0, 1'b0, 1'b0);
      pulse('0, '0, '0, '0, 1'b1, 1'b0);
      chk("R11 masked", status0_o, 32'h802);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule